// File: doc/BRIEF.md
# Configurable Timer Counter Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on a count enable taken from one of eight sources. Four are internal rates derived from the system clock: divided by 1, 2, 4 or 8. The other four are asynchronous external clock pins, each sampled into the system clock domain before its edges are detected. Two general registers, A and B, sit beside the counter. Each can act as a compare register, which flags equality with the counter. Each can instead act as a capture register, which stores the counter value on a rising edge of its own capture pin.

A 7-bit control word is written through a simple write strobe. It selects the count source, which external edges count, and what clears the counter. The counter can be cleared by an event on register A, by an event on register B, or by a group-wide clear strobe shared with sibling channels. The group strobe takes effect only when this channel's sync-enable input is high. A register's event is its compare match in compare mode and its capture in capture mode. A phase-mode input forces an external source to count both edges, whatever the edge field holds.

Top module: `tmr_channel`

## Requirements
- R1: While reset is held, the counter reads 0, the control word reads 0, and both general registers read 0xFFFF.
- R2: Control bits [2:0] select the source. Codes 000, 001, 010 and 011 advance the counter once every 1, 2, 4 and 8 system clocks respectively.
- R3: Source codes 100, 101, 110 and 111 count edges of external pins 0, 1, 2 and 3. Edges on pins that are not selected have no effect on the counter.
- R4: Control bits [4:3] pick the external edge. 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both edges. A counted edge is seen on the counter three system clocks after the pin changes.
- R5: While phase_mode is high, an external source counts both edges, whatever value control bits [4:3] hold.
- R6: With control bits [6:5] at 00, the counter is never cleared, and it wraps from 0xFFFF to 0x0000.
- R7: Control code 01 clears on a register A event and code 10 clears on a register B event. For a register in compare mode the event is counter == register. A clear wins over a count in the same cycle, so a divide-by-1 counter runs from 0 to the register value and back to 0.
- R8: For a register in capture mode, a rising edge on its capture pin loads the counter value into the register. If that register is the selected clear source, the counter also goes to 0.
- R9: Control code 11 clears the counter when group_clr is high and sync_en is high. group_clr has no effect when sync_en is low or when the clear code is not 11.
- R10: match_a and match_b are high while their register is in compare mode and equals the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word: [6:5] clear select, [4:3] edge select, [2:0] source select |
| gra_we | input | 1 | Write strobe for register A |
| grb_we | input | 1 | Write strobe for register B |
| gr_wdata | input | 16 | Write data for the general registers |
| gra_capture | input | 1 | 1 = register A in capture mode, 0 = compare mode |
| grb_capture | input | 1 | 1 = register B in capture mode, 0 = compare mode |
| cap_pin | input | 2 | Asynchronous capture pins: bit 0 for A, bit 1 for B |
| ext_clk | input | 4 | Asynchronous external clock pins 0 to 3 |
| phase_mode | input | 1 | Forces both-edge counting on external sources |
| sync_en | input | 1 | Channel takes part in the group clear |
| group_clr | input | 1 | Group-wide synchronous clear strobe |
| count | output | 16 | Counter value |
| ctl | output | 7 | Current control word |
| gra | output | 16 | Register A value |
| grb | output | 16 | Register B value |
| match_a | output | 1 | Register A compare match |
| match_b | output | 1 | Register B compare match |

## Verification
The bench builds the channel with its defaults: a 16-bit counter and a two-stage synchronizer. With a 16-bit counter, the wrap from 0xFFFF to 0 is reached in a single divide-by-1 run of about 65 thousand cycles. With two synchronizer stages, the latency from a pin change to a counter change is fixed at three clocks, so every edge test can sample in an exact cycle. The prescaler windows are 64 cycles long, a multiple of every divide ratio, so the expected increments do not depend on the divider phase.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'b00,
        CLR_A     = 2'b01,
        CLR_B     = 2'b10,
        CLR_GROUP = 2'b11
    } clr_sel_e;

    typedef struct packed {
        clr_sel_e    clr;
        logic [1:0]  edg;
        logic [2:0]  src;
    } ctl_t;

    localparam int CTL_W  = $bits(ctl_t);
    localparam int N_EXT  = 4;
    localparam int N_RATE = 4;

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tick
);
    localparam int DIV_W = (TAPS > 1) ? TAPS - 1 : 1;

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick[0] = 1'b1;
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        assign tick[k] = &div_q[k-1:0];
    end

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], pins_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign cur_o[g]  = sh_q[STAGES-1];
        assign prev_o[g] = sh_q[STAGES];
    end

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [6:0]       ctl_wdata,
    input  logic             gra_we,
    input  logic             grb_we,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic             gra_capture,
    input  logic             grb_capture,
    input  logic [1:0]       cap_pin,
    input  logic [3:0]       ext_clk,
    input  logic             phase_mode,
    input  logic             sync_en,
    input  logic             group_clr,
    output logic [CNT_W-1:0] count,
    output logic [6:0]       ctl,
    output logic [CNT_W-1:0] gra,
    output logic [CNT_W-1:0] grb,
    output logic             match_a,
    output logic             match_b
);
    localparam int N_PINS = N_EXT + 2;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] gra;
        logic [CNT_W-1:0] grb;
    } st_t;

    st_t st_d, st_q;

    logic [N_RATE-1:0] tick;
    logic [N_PINS-1:0] pin_cur, pin_prev;
    logic [N_EXT-1:0]  ext_rise, ext_fall;
    logic [1:0]        cap_rise;
    logic              sel_rise, sel_fall, cnt_en;
    logic              hit_a, hit_b, evt_a, evt_b, do_clr;

    tmr_prescale #(.TAPS(N_RATE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tmr_edge_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins_i({cap_pin, ext_clk}),
        .cur_o (pin_cur),
        .prev_o(pin_prev)
    );

    assign ext_rise = pin_cur[N_EXT-1:0] & ~pin_prev[N_EXT-1:0];
    assign ext_fall = ~pin_cur[N_EXT-1:0] & pin_prev[N_EXT-1:0];
    assign cap_rise = pin_cur[N_PINS-1:N_EXT] & ~pin_prev[N_PINS-1:N_EXT];

    always_comb begin
        st_d = st_q;

        // count enable from the selected source
        sel_rise = ext_rise[st_q.ctl.src[1:0]];
        sel_fall = ext_fall[st_q.ctl.src[1:0]];
        if (st_q.ctl.src[2]) begin
            if (phase_mode) begin
                cnt_en = sel_rise | sel_fall;
            end else begin
                case (st_q.ctl.edg)
                    2'b00:   cnt_en = sel_rise;
                    2'b01:   cnt_en = sel_fall;
                    default: cnt_en = sel_rise | sel_fall;
                endcase
            end
        end else begin
            cnt_en = tick[st_q.ctl.src[1:0]];
        end

        // per-register events follow each register's role
        hit_a = (st_q.cnt == st_q.gra);
        hit_b = (st_q.cnt == st_q.grb);
        evt_a = gra_capture ? cap_rise[0] : hit_a;
        evt_b = grb_capture ? cap_rise[1] : hit_b;

        case (st_q.ctl.clr)
            CLR_A:     do_clr = evt_a;
            CLR_B:     do_clr = evt_b;
            CLR_GROUP: do_clr = sync_en & group_clr;
            default:   do_clr = 1'b0;
        endcase

        if (do_clr)      st_d.cnt = '0;
        else if (cnt_en) st_d.cnt = st_q.cnt + 1'b1;

        if (gra_capture && cap_rise[0]) st_d.gra = st_q.cnt;
        else if (gra_we)                st_d.gra = gr_wdata;

        if (grb_capture && cap_rise[1]) st_d.grb = st_q.cnt;
        else if (grb_we)                st_d.grb = gr_wdata;

        if (ctl_we) st_d.ctl = ctl_t'(ctl_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= '0;
            st_q.cnt <= '0;
            st_q.gra <= '1;
            st_q.grb <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign ctl     = st_q.ctl;
    assign gra     = st_q.gra;
    assign grb     = st_q.grb;
    assign match_a = ~gra_capture & hit_a;
    assign match_b = ~grb_capture & hit_b;

endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ctl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] gra,
    input logic [CNT_W-1:0] grb,
    input logic             gra_capture,
    input logic             grb_capture,
    input logic             sync_en,
    input logic             group_clr,
    input logic [1:0]       cap_evt
);
    // R6
    no_clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl[6:5]) == 2'b00 && cnt != $past(cnt)) |-> cnt == CNT_W'($past(cnt) + 1'b1));

    // R7
    cmp_a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[6:5] == 2'b01 && !gra_capture && cnt == gra) |=> cnt == '0);

    // R7
    cmp_b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[6:5] == 2'b10 && !grb_capture && cnt == grb) |=> cnt == '0);

    // R8
    cap_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gra_capture && cap_evt[0]) |=> gra == $past(cnt));

    // R8
    cap_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grb_capture && cap_evt[1]) |=> grb == $past(cnt));

    // R9
    group_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[6:5] == 2'b11 && sync_en && group_clr) |=> cnt == '0);

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .cnt        (count),
    .gra        (gra),
    .grb        (grb),
    .gra_capture(gra_capture),
    .grb_capture(grb_capture),
    .sync_en    (sync_en),
    .group_clr  (group_clr),
    .cap_evt    (cap_rise)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [6:0]  ctl_wdata = '0;
    logic        gra_we = 1'b0, grb_we = 1'b0;
    logic [15:0] gr_wdata = '0;
    logic        gra_capture = 1'b0, grb_capture = 1'b0;
    logic [1:0]  cap_pin = '0;
    logic [3:0]  ext_clk = '0;
    logic        phase_mode = 1'b0, sync_en = 1'b0, group_clr = 1'b0;
    logic [15:0] count, gra, grb;
    logic [6:0]  ctl;
    logic        match_a, match_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .gra_we(gra_we), .grb_we(grb_we), .gr_wdata(gr_wdata),
        .gra_capture(gra_capture), .grb_capture(grb_capture),
        .cap_pin(cap_pin), .ext_clk(ext_clk), .phase_mode(phase_mode),
        .sync_en(sync_en), .group_clr(group_clr), .count(count), .ctl(ctl),
        .gra(gra), .grb(grb), .match_a(match_a), .match_b(match_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [1:0] clr, input logic [1:0] edg, input logic [2:0] src);
        ctl_we = 1'b1; ctl_wdata = {clr, edg, src};
        tick(1);
        ctl_we = 1'b0;
    endtask

    task automatic wr_gr(input bit b, input logic [15:0] v);
        gr_wdata = v;
        if (b) grb_we = 1'b1; else gra_we = 1'b1;
        tick(1);
        gra_we = 1'b0; grb_we = 1'b0;
    endtask

    task automatic zero_cnt(input logic [2:0] src);
        wr_ctl(2'b11, 2'b00, src);
        sync_en = 1'b1; group_clr = 1'b1;
        tick(1);
        group_clr = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 count", count, 16'h0);
        chk("R1 ctl", ctl, 7'h0);
        chk("R1 gra", gra, 16'hFFFF);
        chk("R1 grb", grb, 16'hFFFF);
    endtask

    task automatic test_prescale();
        for (int c = 0; c < 4; c++) begin
            logic [15:0] a;
            wr_ctl(2'b00, 2'b00, 3'(c));
            a = count;
            tick(64);
            chk($sformatf("R2 src %0d", c), 32'(count - a), 32'(64 >> c));
        end
    endtask

    // for each pin and edge code: unselected pin ignored, then one pulse
    task automatic test_external();
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 4; e++) begin
                logic [15:0] a;
                int other, exp1, exp2;
                other = (p + 1) % 4;
                wr_ctl(2'b00, 2'(e), 3'(4 + p));
                a = count;
                ext_clk[other] = 1'b1; tick(5); ext_clk[other] = 1'b0; tick(5);
                chk($sformatf("R3 pin %0d other ignored", p), 32'(count - a), 0);
                exp1 = (e == 1) ? 0 : 1;
                exp2 = (e >= 2) ? 2 : 1;
                ext_clk[p] = 1'b1; tick(5);
                chk($sformatf("R4 pin %0d edge %0d high", p, e), 32'(count - a), exp1);
                ext_clk[p] = 1'b0; tick(5);
                chk($sformatf("R4 pin %0d edge %0d low", p, e), 32'(count - a), exp2);
            end
        end
    endtask

    task automatic test_phase();
        phase_mode = 1'b1;
        for (int e = 0; e < 2; e++) begin
            logic [15:0] a;
            wr_ctl(2'b00, 2'(e), 3'b110);
            a = count;
            ext_clk[2] = 1'b1; tick(5);
            chk($sformatf("R5 edge %0d high", e), 32'(count - a), 1);
            ext_clk[2] = 1'b0; tick(5);
            chk($sformatf("R5 edge %0d low", e), 32'(count - a), 2);
        end
        phase_mode = 1'b0;
    endtask

    task automatic test_group();
        logic [15:0] v;
        wr_ctl(2'b11, 2'b00, 3'b000);
        sync_en = 1'b0;
        v = count; group_clr = 1'b1; tick(1); group_clr = 1'b0;
        chk("R9 sync_en low ignored", count, 16'(v + 1));
        sync_en = 1'b1;
        group_clr = 1'b1; tick(1); group_clr = 1'b0;
        chk("R9 group clear", count, 16'h0);
        wr_ctl(2'b00, 2'b00, 3'b000);
        v = count; group_clr = 1'b1; tick(1); group_clr = 1'b0;
        chk("R9 clear code 00 ignores strobe", count, 16'(v + 1));
    endtask

    task automatic test_wrap();
        logic [15:0] v;
        wr_ctl(2'b00, 2'b00, 3'b000);
        v = count;
        tick(int'(16'hFFFF - v));
        chk("R6 reaches max", count, 16'hFFFF);
        tick(1);
        chk("R6 wraps to zero", count, 16'h0);
    endtask

    task automatic test_compare(input bit b, input logic [15:0] lim, input logic [15:0] other_v);
        logic [15:0] mx, prev, c;
        int err, merr;
        wr_gr(b, lim);
        wr_gr(!b, other_v);
        zero_cnt(3'b000);
        wr_ctl(b ? 2'b10 : 2'b01, 2'b00, 3'b000);
        mx = 0; err = 0; merr = 0; prev = count;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            c = count;
            if (c > mx) mx = c;
            if (prev == lim && c != 0) err++;
            if ((c == lim) != (b ? match_b : match_a)) merr++;
            prev = c;
        end
        chk($sformatf("R7 reg %0d peak", b), mx, lim);
        chk($sformatf("R7 reg %0d restart", b), err, 0);
        chk($sformatf("R10 reg %0d match flag", b), merr, 0);
    endtask

    task automatic pulse_ext0(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk[0] = 1'b1; tick(5); ext_clk[0] = 1'b0; tick(5);
        end
    endtask

    task automatic test_capture();
        gra_capture = 1'b1; grb_capture = 1'b1;
        zero_cnt(3'b100);
        chk("R9 zeroed before capture", count, 16'h0);
        pulse_ext0(3);
        cap_pin[0] = 1'b1; tick(5);
        chk("R8 capture A value", gra, 16'd3);
        chk("R8 capture A no clear under code 11", count, 16'd3);
        chk("R10 match_a low in capture mode", match_a, 1'b0);
        cap_pin[0] = 1'b0; tick(5);
        wr_ctl(2'b01, 2'b00, 3'b100);
        pulse_ext0(2);
        cap_pin[0] = 1'b1; tick(5);
        chk("R8 capture A value with clear", gra, 16'd5);
        chk("R8 capture A clears", count, 16'h0);
        cap_pin[0] = 1'b0; tick(5);
        wr_ctl(2'b10, 2'b00, 3'b100);
        pulse_ext0(2);
        cap_pin[1] = 1'b1; tick(5);
        chk("R8 capture B value", grb, 16'd2);
        chk("R8 capture B clears", count, 16'h0);
        chk("R8 A untouched by B capture", gra, 16'd5);
        cap_pin[1] = 1'b0; tick(5);
        gra_capture = 1'b0; grb_capture = 1'b0;
    endtask

    initial begin
        tick(3);
        test_reset();
        rst_n = 1'b1;
        tick(2);
        test_prescale();
        test_external();
        test_phase();
        test_group();
        test_compare(1'b0, 16'd5, 16'hFFFF);
        test_compare(1'b1, 16'd3, 16'd2);
        test_capture();
        test_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1520000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule